// File: doc/BRIEF.md
# Marker-Framed Serial Byte Receiver

This block collects serial bytes that arrive as nine-bit frames. Each frame starts with a one that acts as a start marker, followed by eight data bits. Bits are accepted on cycles where the bit-valid enable is high, which stands for the clock recovered from the line. They enter a nine-stage shift register. No bit counter is used. A frame is complete when the leading one has reached the last stage.

One cycle after that, the block raises a byte-ready flag and drops the marker. The held register then contains exactly the eight data bits. A host reads the byte by driving its read line high while pulling the active-low strobe low. For as long as both conditions hold, the byte is driven onto the output bus, which is modelled as an output enable plus data. The same condition clears the flag and empties the register, so the next frame can start.

Top module: `marker_byte_rx`

## Requirements
- R1: After reset, `byte_rdy` is 0, `bus_oe` is 0, and the register is empty, so an immediate read presents 0x00.
- R2: The register advances only on cycles where `bit_en` is 1. On other cycles, `bit_in` has no effect on the received byte.
- R3: `byte_rdy` rises exactly one clock after the edge that stores the ninth bit of a frame, which is when the marker reaches the last stage. It does not rise earlier.
- R4: The marker is discarded. The byte on the bus holds the eight bits that follow the marker, with the first of them in bit 7 and the last in bit 0.
- R5: A read needs `rd` = 1 and `strobe_n` = 0 together. If only one of the two holds, `bus_oe` stays 0 and `byte_rdy` is unchanged.
- R6: While the read condition holds, `bus_oe` is 1 and `bus_data` shows the held byte. One clock after a read cycle, `byte_rdy` is 0 and the register is empty, so a second read shows 0x00.
- R7: While `byte_rdy` is 1, further bits are not shifted in. The held byte is unchanged by any `bit_en` activity.
- R8: When no read is in progress, `bus_oe` is 0 and `bus_data` is 0x00.
- R9: Zero bits that arrive while the register is empty do not start a frame. A frame that follows such idle zeros is received correctly.
- R10: A read during a partial frame aborts that frame. It empties the register, leaves `byte_rdy` at 0, and lets the next complete frame be received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bit_en | input | 1 | Recovered bit clock, used as an enable: one bit is sampled per high cycle |
| bit_in | input | 1 | Recovered serial data |
| rd | input | 1 | Host read line, active high |
| strobe_n | input | 1 | Host strobe, active low |
| byte_rdy | output | 1 | Byte-available flag |
| bus_oe | output | 1 | Output enable of the byte bus; 0 means high impedance |
| bus_data | output | 8 | Byte bus data, valid while bus_oe is 1 |

## Verification
The assertions check several rules on every cycle:
- the flag follows the marker reaching the last stage by exactly one clock;
- the last stage is clear whenever the flag is set;
- the held byte and the flag stay stable until a read;
- a read clears both;
- the bus enable follows the combined read condition.

Only the bench scenarios can show the remaining behaviours:
- that bit order lands the first data bit in bit 7;
- that idle zeros and gaps between bits leave the byte intact;
- that an aborted partial frame is followed by a clean reception;
- that one-sided read attempts are ignored.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  localparam logic MARKER_BIT = 1'b1;

  function automatic int frame_len(input int data_w);
    return data_w + 1;
  endfunction
endpackage

// File: rtl/mbr_rst_sync.sv
module mbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/mbr_shift.sv
module mbr_shift
  import mbr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              rdy_i,
  input  logic              rd_act_i,
  output logic              marker_end_o,
  output logic [DATA_W-1:0] byte_o
);
  localparam int FRAME_W = frame_len(DATA_W);
  localparam int TOP     = FRAME_W - 1;

  logic [FRAME_W-1:0] sr_q;
  logic [FRAME_W-1:0] sr_d;
  logic               shift_en;
  logic               sr_en;

  // Shifting stops once a frame is complete and while a byte is held.
  assign shift_en = bit_en & ~rdy_i & (sr_q[TOP] != MARKER_BIT);

  always_comb begin
    sr_d  = sr_q;
    sr_en = 1'b0;
    if (rd_act_i) begin
      sr_d  = '0;
      sr_en = 1'b1;
    end else if (sr_q[TOP] == MARKER_BIT) begin
      sr_d[TOP] = 1'b0;              // drop the marker as overflow
      sr_en     = 1'b1;
    end else if (shift_en) begin
      sr_d  = {sr_q[TOP-1:0], bit_in};
      sr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign marker_end_o = (sr_q[TOP] == MARKER_BIT);
  assign byte_o       = sr_q[DATA_W-1:0];

  assert_marker_gone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_i |-> !marker_end_o);
  assert_hold_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_i && !rd_act_i) |=> $stable(byte_o));
  assert_read_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act_i |=> (byte_o == '0 && !marker_end_o));
endmodule

// File: rtl/mbr_flag.sv
module mbr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic marker_end_i,
  input  logic rd_act_i,
  output logic rdy_o
);
  logic rdy_q;
  logic rdy_d;

  always_comb begin
    rdy_d = rdy_q;
    if (rd_act_i)          rdy_d = 1'b0;
    else if (marker_end_i) rdy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= rdy_d;
  end

  assign rdy_o = rdy_q;

  assert_flag_follows_marker_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (marker_end_i && !rd_act_i) |=> rdy_o);
  assert_flag_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_o && !rd_act_i) |=> rdy_o);
  assert_flag_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act_i |=> !rdy_o);
endmodule

// File: rtl/mbr_bus.sv
module mbr_bus #(
  parameter int DATA_W = 8
) (
  input  logic              rd,
  input  logic              strobe_n,
  input  logic [DATA_W-1:0] byte_i,
  output logic              rd_act_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    rd_act_o = rd & ~strobe_n;
    oe_o     = rd_act_o;
    data_o   = rd_act_o ? byte_i : '0;
  end
endmodule

// File: rtl/marker_byte_rx.sv
module marker_byte_rx #(
  parameter int DATA_W     = 8,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              rd,
  input  logic              strobe_n,
  output logic              byte_rdy,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_data
);
  logic              rst_n_s;
  logic              rd_act;
  logic              marker_end;
  logic [DATA_W-1:0] held_byte;

  mbr_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  mbr_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n_s), .bit_en(bit_en), .bit_in(bit_in),
    .rdy_i(byte_rdy), .rd_act_i(rd_act), .marker_end_o(marker_end),
    .byte_o(held_byte));

  mbr_flag u_flag (
    .clk(clk), .rst_n(rst_n_s), .marker_end_i(marker_end),
    .rd_act_i(rd_act), .rdy_o(byte_rdy));

  mbr_bus #(.DATA_W(DATA_W)) u_bus (
    .rd(rd), .strobe_n(strobe_n), .byte_i(held_byte),
    .rd_act_o(rd_act), .oe_o(bus_oe), .data_o(bus_data));

  assert_bus_enable_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_oe == (rd && !strobe_n));
  assert_idle_bus_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !bus_oe |-> (bus_data == '0));
endmodule

// File: tb/marker_byte_rx_test.sv
module marker_byte_rx_test;
  logic       clk = 1'b0;
  logic       rst_n, bit_en, bit_in, rd, strobe_n;
  logic       byte_rdy, bus_oe;
  logic [7:0] bus_data;
  int         n_tests = 0;
  int         n_fail  = 0;
  bit         done    = 0;

  always #2 clk = ~clk;

  marker_byte_rx uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in), .rd(rd),
    .strobe_n(strobe_n), .byte_rdy(byte_rdy), .bus_oe(bus_oe),
    .bus_data(bus_data));

  // Bit k of a frame: k=0 is the marker, then data MSB first.
  function automatic logic frame_bit(input logic [7:0] b, input int k);
    return (k == 0) ? 1'b1 : b[8-k];
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_en = 1'b0;
      bit_in = 1'($urandom);
    end
  endtask

  task automatic send_bit(input logic b, input int gap);
    @(negedge clk);
    bit_en = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
    bit_in = 1'($urandom);
    if (gap > 0) idle(gap);
  endtask

  // Sends a frame; returns at the negedge right after the ninth bit edge.
  task automatic send_frame(input logic [7:0] b, input bit gaps);
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      bit_en = 1'b1;
      bit_in = frame_bit(b, k);
      @(negedge clk);
      bit_en = 1'b0;
      bit_in = 1'($urandom);
      if (k < 8 && gaps) idle(int'($urandom_range(0, 3)));
    end
  endtask

  task automatic do_read(input string req, input logic [7:0] exp);
    @(negedge clk);
    rd = 1'b1;
    strobe_n = 1'b0;
    #1;
    check({req, " oe"}, bus_oe, 1);
    check({req, " data"}, bus_data, exp);
    @(negedge clk);
    rd = 1'b0;
    strobe_n = 1'b1;
    #1;
    check({req, " rdy cleared"}, byte_rdy, 0);
    check({req, " oe idle"}, bus_oe, 0);
  endtask

  task automatic frame_and_read(input string req, input logic [7:0] b,
                                input bit gaps);
    send_frame(b, gaps);
    #1;
    check({req, " rdy not early"}, byte_rdy, 0);
    @(negedge clk);
    #1;
    check({req, " rdy one clock later"}, byte_rdy, 1);
    do_read(req, b);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b0; rd = 1'b0; strobe_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    check("R1 rdy", byte_rdy, 0);
    check("R1 oe", bus_oe, 0);
    check("R8 idle data", bus_data, 0);
    do_read("R1 empty read", 8'h00);

    // R3/R4 directed, back-to-back bits
    frame_and_read("R3 R4 A5", 8'hA5, 0);
    frame_and_read("R4 80", 8'h80, 0);
    frame_and_read("R4 01", 8'h01, 0);

    // R2 gaps with noise on bit_in
    frame_and_read("R2 gaps 3C", 8'h3C, 1);

    // R9 idle zeros before a frame
    for (int i = 0; i < 12; i++) send_bit(1'b0, 0);
    #1;
    check("R9 no frame from zeros", byte_rdy, 0);
    frame_and_read("R9 after zeros 6E", 8'h6E, 1);

    // R5 one-sided reads, R7 extra bits ignored
    send_frame(8'hC3, 0);
    idle(1);
    for (int i = 0; i < 5; i++) send_bit(1'($urandom), 0);
    @(negedge clk);
    rd = 1'b1; strobe_n = 1'b1;
    #1;
    check("R5 rd only oe", bus_oe, 0);
    check("R8 rd only data", bus_data, 0);
    @(negedge clk);
    rd = 1'b0; strobe_n = 1'b0;
    #1;
    check("R5 strobe only oe", bus_oe, 0);
    @(negedge clk);
    strobe_n = 1'b1;
    #1;
    check("R5 rdy kept", byte_rdy, 1);
    do_read("R7 held byte C3", 8'hC3);
    do_read("R6 second read empty", 8'h00);

    // R10 abort partial frame
    send_bit(1'b1, 0);
    send_bit(1'b0, 1);
    send_bit(1'b1, 0);
    @(negedge clk);
    rd = 1'b1; strobe_n = 1'b0;
    @(negedge clk);
    rd = 1'b0; strobe_n = 1'b1;
    #1;
    check("R10 rdy low after abort", byte_rdy, 0);
    frame_and_read("R10 next frame 5A", 8'h5A, 0);

    // Random frames
    for (int i = 0; i < 25; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      for (int z = 0; z < int'($urandom_range(0, 4)); z++) send_bit(1'b0, 0);
      frame_and_read("R4 random", b, 1);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule